// File: doc/BRIEF.md
# CAN Acceptance Filter Bank

This block decides whether a received CAN frame identifier is wanted by the controller. It checks the identifier against a row of configurable filter banks. For each frame it reports three things: whether the frame is accepted, which of two receive FIFOs it should go to, and a match index that tells software which sub-filter caught it. The frame source presents one identifier word per strobe. The verdict appears on the next clock cycle. Receiving the frame and storing it are left to the neighbouring logic.

Each bank holds two 32-bit words and one bit in each of four bank vectors: mode, scale, FIFO assignment and activation. With those settings, one bank can act as any of the following:
- one 32-bit identifier/mask pair;
- two exact 32-bit identifiers;
- two 16-bit identifier/mask pairs;
- four exact 16-bit identifiers.

Software writes the settings through a simple write port. Bank contents can change only while a filter-init bit in the control word is set. The control word also holds a split point. Banks at or above the split belong to a second controller, so this block ignores them.

Top module: `can_accept_filter`

## Requirements
- R1: After reset no result is flagged, all banks are inactive and the filter-init bit is set, so no frame is accepted until software configures the block.
- R2: A result (`res_vld_o`) is asserted exactly in the cycle after each `frm_vld_i` strobe and is low otherwise. `accept_o` is only ever high together with `res_vld_o`.
- R3: Identifier word layout: bits 31:21 standard ID, bits 31:3 extended ID, bit 2 IDE, bit 1 RTR, bit 0 zero. In 32-bit mask mode (scale=1, mode=0), word A is the identifier and word B is the mask. A bit matches when its mask bit is 0 or the identifier bits are equal.
- R4: In 32-bit list mode (scale=1, mode=1), the frame matches when all 32 bits equal word A (sub-filter 0) or all 32 bits equal word B (sub-filter 1).
- R5: In 16-bit mask mode (scale=0, mode=0), the frame is packed to 16 bits as {ID[10:0], RTR, IDE, word bits 20:18}. Pair 0 uses word A, pair 1 uses word B, each holding the identifier in bits 15:0 and the mask in bits 31:16.
- R6: In 16-bit list mode (scale=0, mode=1), the packed frame is compared exactly against four identifiers. In sub-filter order these are word A low half, word A high half, word B low half and word B high half.
- R7: An inactive bank never matches. When no owned, active bank matches, `accept_o`, `fifo_o` and `idx_o` are all 0.
- R8: When several filters match, the lowest-numbered bank wins, and within that bank the lowest-numbered sub-filter wins.
- R9: `fifo_o` is the winning bank's FIFO bit. `idx_o` equals the number of sub-filters in lower-numbered owned banks assigned to the same FIFO, plus the winner's sub-filter number. A bank counts 1, 2, 2 or 4 sub-filters for 32-bit mask, 32-bit list, 16-bit mask and 16-bit list respectively.
- R10: Write address map:
  - 0x00: control word (bit 0 filter-init, bits 13:8 split).
  - 0x01: mode vector (1 = list).
  - 0x02: scale vector (1 = 32-bit).
  - 0x03: FIFO vector (1 = FIFO 1).
  - 0x04: activation vector.
  - 0x20+2b: word A of bank b.
  - 0x21+2b: word B of bank b.

  The control word and the activation vector are always writable. Writes to the other addresses are ignored while filter-init is 0.
- R11: While filter-init is set, no frame is accepted.
- R12: Banks numbered at or above the split field are ignored. They never match and are not counted in `idx_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | ADDR_W | Configuration write address |
| cfg_wdata_i | input | 32 | Configuration write data |
| frm_vld_i | input | 1 | Identifier word valid |
| frm_id_i | input | 32 | Identifier word in mailbox layout |
| res_vld_o | output | 1 | Result valid, one cycle after strobe |
| accept_o | output | 1 | Frame accepted |
| fifo_o | output | 1 | Destination FIFO of accepted frame |
| idx_o | output | IDX_W | Match index within that FIFO |

## Verification
Two situations are hard to reach from the ports:
- A frame that several filters in different banks and FIFOs would take at once.
- A configuration write arriving while the block is unlocked.

To reach the first, the stimulus sets up overlapping filters: a 32-bit mask in bank 0 and a 16-bit list entry in bank 3 both catch standard ID 0x123. A duplicated list entry inside bank 3 tests priority within a bank. Deactivating bank 0 then exposes the lower-priority winner and its index.

For the second, locked writes are shown to have no effect by sending a frame whose verdict would change if the write had landed. The same write is then repeated under filter-init, and its effect is observed.

// File: rtl/can_flt_pkg.sv
package can_flt_pkg;
  localparam int unsigned WORD_W = 32;

  typedef struct packed {
    logic              list_m;   // 1 = exact identifier list
    logic              wide;     // 1 = 32-bit scale
    logic              act;
    logic [WORD_W-1:0] wa;
    logic [WORD_W-1:0] wb;
  } bank_cfg_t;

  // 16-bit view: ID[10:0], RTR, IDE, top three extended bits
  function automatic logic [15:0] pack16(input logic [WORD_W-1:0] w);
    return {w[31:21], w[1], w[2], w[20:18]};
  endfunction

  function automatic logic [2:0] sub_count(input logic list_m, input logic wide);
    if (wide) return list_m ? 3'd2 : 3'd1;
    return list_m ? 3'd4 : 3'd2;
  endfunction
endpackage

// File: rtl/can_flt_cfg.sv
module can_flt_cfg
  import can_flt_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned SPLIT_W   = 6
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [WORD_W-1:0]    wdata_i,
  output bank_cfg_t            bank_o [NUM_BANKS],
  output logic [NUM_BANKS-1:0] fifo_o,
  output logic                 init_o,
  output logic [SPLIT_W-1:0]   split_o
);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_MODE  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_SCALE = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_FIFO  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_ACT   = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_REGS  = ADDR_W'(32);

  logic                 init_q;
  logic [SPLIT_W-1:0]   split_q;
  logic [NUM_BANKS-1:0] mode_q, scale_q, fifo_q, act_q;
  logic                 is_reg;
  logic [ADDR_W-1:0]    reg_bank;

  assign is_reg   = addr_i >= A_REGS;
  assign reg_bank = (addr_i - A_REGS) >> 1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_q  <= 1'b1;
      split_q <= SPLIT_W'(NUM_BANKS);
      mode_q  <= '0;
      scale_q <= '0;
      fifo_q  <= '0;
      act_q   <= '0;
    end else if (we_i) begin
      if (addr_i == A_CTRL) begin
        init_q  <= wdata_i[0];
        split_q <= wdata_i[8 +: SPLIT_W];
      end
      if (addr_i == A_ACT) act_q <= wdata_i[NUM_BANKS-1:0];
      if (init_q) begin
        if (addr_i == A_MODE)  mode_q  <= wdata_i[NUM_BANKS-1:0];
        if (addr_i == A_SCALE) scale_q <= wdata_i[NUM_BANKS-1:0];
        if (addr_i == A_FIFO)  fifo_q  <= wdata_i[NUM_BANKS-1:0];
      end
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [WORD_W-1:0] wa_q, wb_q;
    logic              sel;
    assign sel = we_i && init_q && is_reg && (reg_bank == ADDR_W'(b));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        wa_q <= '0;
        wb_q <= '0;
      end else if (sel) begin
        if (addr_i[0]) wb_q <= wdata_i;
        else           wa_q <= wdata_i;
      end
    end

    assign bank_o[b] = '{list_m: mode_q[b], wide: scale_q[b], act: act_q[b],
                         wa: wa_q, wb: wb_q};

    // R10
    word_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && !init_q && is_reg && reg_bank == ADDR_W'(b)) |=> ($stable(wa_q) && $stable(wb_q)));
  end

  assign fifo_o  = fifo_q;
  assign init_o  = init_q;
  assign split_o = split_q;

  // R10
  mode_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !init_q && addr_i == A_MODE) |=> $stable(mode_q));
endmodule

// File: rtl/can_flt_bank_match.sv
module can_flt_bank_match
  import can_flt_pkg::*;
(
  input  bank_cfg_t         cfg_i,
  input  logic [WORD_W-1:0] id_i,
  output logic              hit_o,
  output logic [1:0]        sub_o
);
  logic [15:0] p;
  logic [3:0]  h;

  assign p = pack16(id_i);

  always_comb begin
    h = '0;
    unique case ({cfg_i.wide, cfg_i.list_m})
      2'b10: h[0] = ((id_i ^ cfg_i.wa) & cfg_i.wb) == '0;
      2'b11: begin
        h[0] = id_i == cfg_i.wa;
        h[1] = id_i == cfg_i.wb;
      end
      2'b00: begin
        h[0] = ((p ^ cfg_i.wa[15:0]) & cfg_i.wa[31:16]) == '0;
        h[1] = ((p ^ cfg_i.wb[15:0]) & cfg_i.wb[31:16]) == '0;
      end
      default: h = {p == cfg_i.wb[31:16], p == cfg_i.wb[15:0],
                    p == cfg_i.wa[31:16], p == cfg_i.wa[15:0]};
    endcase
  end

  always_comb begin
    sub_o = 2'd0;
    for (int s = 3; s >= 0; s--) if (h[s]) sub_o = 2'(s);
  end

  assign hit_o = cfg_i.act && (h != '0);
endmodule

// File: rtl/can_flt_select.sv
module can_flt_select
  import can_flt_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned IDX_W     = 8
) (
  input  logic [NUM_BANKS-1:0] hit_i,
  input  logic [NUM_BANKS-1:0] own_i,
  input  logic [NUM_BANKS-1:0] fifo_i,
  input  logic [NUM_BANKS-1:0] mode_i,
  input  logic [NUM_BANKS-1:0] scale_i,
  input  logic [1:0]           sub_i [NUM_BANKS],
  output logic [NUM_BANKS-1:0] gnt_o,
  output logic                 acc_o,
  output logic                 fifo_o,
  output logic [IDX_W-1:0]     idx_o
);
  logic [IDX_W-1:0] base [NUM_BANKS];
  logic             seen;

  // index offset of each bank within its own FIFO
  always_comb begin
    for (int b = 0; b < NUM_BANKS; b++) begin
      base[b] = '0;
      for (int j = 0; j < b; j++)
        if (own_i[j] && fifo_i[j] == fifo_i[b])
          base[b] = base[b] + IDX_W'(sub_count(mode_i[j], scale_i[j]));
    end
  end

  always_comb begin
    seen   = 1'b0;
    gnt_o  = '0;
    acc_o  = 1'b0;
    fifo_o = 1'b0;
    idx_o  = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (hit_i[b] && own_i[b] && !seen) begin
        seen     = 1'b1;
        gnt_o[b] = 1'b1;
        acc_o    = 1'b1;
        fifo_o   = fifo_i[b];
        idx_o    = base[b] + IDX_W'(sub_i[b]);
      end
    end
  end
endmodule

// File: rtl/can_accept_filter.sv
module can_accept_filter
  import can_flt_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned IDX_W     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [31:0]       cfg_wdata_i,
  input  logic              frm_vld_i,
  input  logic [31:0]       frm_id_i,
  output logic              res_vld_o,
  output logic              accept_o,
  output logic              fifo_o,
  output logic [IDX_W-1:0]  idx_o
);
  localparam int unsigned SPLIT_W = 6;

  bank_cfg_t            bank [NUM_BANKS];
  logic [NUM_BANKS-1:0] fifo_v, hit, own, mode_v, scale_v, gnt;
  logic [1:0]           sub [NUM_BANKS];
  logic                 init;
  logic [SPLIT_W-1:0]   split;
  logic                 acc_c, fifo_c;
  logic [IDX_W-1:0]     idx_c;

  can_flt_cfg #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W), .SPLIT_W(SPLIT_W)) u_cfg (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .bank_o(bank), .fifo_o(fifo_v), .init_o(init), .split_o(split)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_match
    can_flt_bank_match u_match (
      .cfg_i(bank[b]), .id_i(frm_id_i), .hit_o(hit[b]), .sub_o(sub[b])
    );
    assign own[b]     = SPLIT_W'(b) < split;
    assign mode_v[b]  = bank[b].list_m;
    assign scale_v[b] = bank[b].wide;
  end

  can_flt_select #(.NUM_BANKS(NUM_BANKS), .IDX_W(IDX_W)) u_sel (
    .hit_i(hit), .own_i(own), .fifo_i(fifo_v), .mode_i(mode_v), .scale_i(scale_v),
    .sub_i(sub), .gnt_o(gnt), .acc_o(acc_c), .fifo_o(fifo_c), .idx_o(idx_c)
  );

  logic take;
  assign take = frm_vld_i && !init && acc_c;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_vld_o <= 1'b0;
      accept_o  <= 1'b0;
      fifo_o    <= 1'b0;
      idx_o     <= '0;
    end else begin
      res_vld_o <= frm_vld_i;
      accept_o  <= take;
      fifo_o    <= take ? fifo_c : 1'b0;
      idx_o     <= take ? idx_c : '0;
    end
  end

  // R2
  latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_vld_i |=> res_vld_o);
  // R2
  idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frm_vld_i |=> !res_vld_o);
  // R2
  acc_vld_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> res_vld_o);
  // R11
  init_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_vld_i && init) |=> !accept_o);
  // R7
  noacc_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept_o |-> (!fifo_o && idx_o == '0));
  // R8
  one_winner_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt));
  // R12
  split_gnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt & ~own) == '0);
endmodule

// File: tb/can_accept_filter_tb_top.sv
module can_accept_filter_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        vld = 1'b0;
  logic [31:0] id = '0;
  logic        res_vld, acc, fifo;
  logic [7:0]  idx;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_accept_filter dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(we), .cfg_addr_i(addr), .cfg_wdata_i(wdata),
    .frm_vld_i(vld), .frm_id_i(id),
    .res_vld_o(res_vld), .accept_o(acc), .fifo_o(fifo), .idx_o(idx)
  );

  typedef struct packed {
    logic [31:0] id;
    logic        acc;
    logic        fifo;
    logic [7:0]  idx;
    logic [7:0]  req;
  } vec_t;

  localparam vec_t VEC [16] = '{
    '{32'h2460_0000, 1'b1, 1'b0, 8'd0, 8'd8},  // R8 bank0 beats bank3
    '{32'h25E0_0000, 1'b1, 1'b0, 8'd0, 8'd3},  // R3 masked low ID bits
    '{32'h25E0_0002, 1'b1, 1'b0, 8'd0, 8'd3},  // R3 RTR not masked in
    '{32'h2660_0000, 1'b0, 1'b0, 8'd0, 8'd7},  // R7 no match
    '{32'h00D5_E6F4, 1'b1, 1'b1, 8'd0, 8'd4},  // R4 extended list
    '{32'h00D5_E6FC, 1'b0, 1'b0, 8'd0, 8'd4},  // R4 one bit off
    '{32'h0AA0_0000, 1'b1, 1'b1, 8'd1, 8'd9},  // R9 second list entry
    '{32'h0AA0_0002, 1'b0, 1'b0, 8'd0, 8'd4},  // R4 RTR differs
    '{32'h4000_0000, 1'b1, 1'b0, 8'd1, 8'd9},  // R9 after bank0 in FIFO0
    '{32'h4000_0002, 1'b0, 1'b0, 8'd0, 8'd5},  // R5 RTR masked
    '{32'h4000_0004, 1'b0, 1'b0, 8'd0, 8'd5},  // R5 IDE masked
    '{32'h6000_0002, 1'b1, 1'b0, 8'd2, 8'd5},  // R5 pair 1
    '{32'h6004_0002, 1'b1, 1'b0, 8'd2, 8'd5},  // R5 ext bits not masked
    '{32'h0200_0000, 1'b1, 1'b1, 8'd2, 8'd6},  // R6 list sub 0
    '{32'h0220_0000, 1'b1, 1'b1, 8'd3, 8'd8},  // R8 sub1 beats sub3
    '{32'h0240_0000, 1'b0, 1'b0, 8'd0, 8'd6}   // R6 not listed
  };

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic send(input logic [31:0] w);
    @(negedge clk);
    vld = 1'b1; id = w;
    @(posedge clk);
    @(negedge clk);
    vld = 1'b0;
  endtask

  task automatic check(input string req, input logic e_vld, input logic e_acc,
                       input logic e_fifo, input logic [7:0] e_idx);
    total++;
    if (res_vld !== e_vld || acc !== e_acc || fifo !== e_fifo || idx !== e_idx) begin
      bad++;
      $display("FAIL %s: got vld=%0b acc=%0b fifo=%0b idx=%0d exp vld=%0b acc=%0b fifo=%0b idx=%0d",
               req, res_vld, acc, fifo, idx, e_vld, e_acc, e_fifo, e_idx);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: got hung exp done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset", 1'b0, 1'b0, 1'b0, 8'd0);
    send(32'h2460_0000);
    check("R1 unconfigured", 1'b1, 1'b0, 1'b0, 8'd0);

    // configure while filter-init is set after reset
    wr(8'h01, 32'h0000_000A);
    wr(8'h02, 32'h0000_0003);
    wr(8'h03, 32'h0000_000A);
    wr(8'h20, 32'h2460_0000); wr(8'h21, 32'hFE00_0000);
    wr(8'h22, 32'h00D5_E6F4); wr(8'h23, 32'h0AA0_0000);
    wr(8'h24, 32'hFFF8_4000); wr(8'h25, 32'hFFF8_6010);
    wr(8'h26, 32'h0220_0200); wr(8'h27, 32'h0220_2460);
    wr(8'h04, 32'h0000_000F);
    wr(8'h00, 32'h0000_0400);

    for (int i = 0; i < 16; i++) begin
      send(VEC[i].id);
      check($sformatf("R%0d vec%0d", VEC[i].req, i), 1'b1, VEC[i].acc, VEC[i].fifo, VEC[i].idx);
    end

    // R2: result lasts a single cycle
    @(negedge clk);
    check("R2 one cycle", 1'b0, 1'b0, 1'b0, 8'd0);

    // R10: locked writes have no effect
    wr(8'h20, 32'h0000_0000);
    send(32'h2460_0000);
    check("R10 word locked", 1'b1, 1'b1, 1'b0, 8'd0);
    wr(8'h01, 32'h0000_000B);
    send(32'h25E0_0000);
    check("R10 mode locked", 1'b1, 1'b1, 1'b0, 8'd0);

    // R7/R10: activation always writable, inactive bank skipped
    wr(8'h04, 32'h0000_000E);
    send(32'h2460_0000);
    check("R7 inactive bank", 1'b1, 1'b1, 1'b1, 8'd4);
    wr(8'h04, 32'h0000_000F);

    // R11: no acceptance under filter-init, writes land
    wr(8'h00, 32'h0000_0401);
    send(32'h2460_0000);
    check("R11 init blocks", 1'b1, 1'b0, 1'b0, 8'd0);
    wr(8'h20, 32'h0000_0000);
    wr(8'h00, 32'h0000_0400);
    send(32'h2460_0000);
    check("R10 write under init", 1'b1, 1'b1, 1'b1, 8'd4);

    // R12: split at bank 2
    wr(8'h00, 32'h0000_0200);
    send(32'h0200_0000);
    check("R12 bank above split", 1'b1, 1'b0, 1'b0, 8'd0);
    send(32'h0AA0_0000);
    check("R12 bank below split", 1'b1, 1'b1, 1'b1, 8'd1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule